// File: doc/BRIEF.md
# Adaptive ADPCM Sample Decoder

This block turns a stream of 4-bit adaptive differential codes into 12-bit signed audio samples. Each code goes in with a one-cycle valid strobe. The decoder reads a quantiser step from a 49-entry table, using a running step index to choose the entry. It scales the step by the code magnitude to get a signed difference and adds that difference to a saturating sample accumulator. It then moves the step index by an amount that depends on the code magnitude.

A small two-state controller sequences the work. In `ST_IDLE` it waits for a code. On the clock edge that samples `code_valid` high, the accumulator and the index are updated and the controller moves to `ST_EMIT`. In that state `out_valid` is high for one cycle to mark the new sample. From `ST_EMIT` the controller returns to `ST_IDLE`, or stays in `ST_EMIT` if another code arrives straight away. A synchronous `clr` forces `ST_IDLE` and zeroes the decoding state. Timing of sample events and buffering of codes belong to the surrounding logic.

Top module: `adpcm_decoder`

## Requirements
- R1: Code bit 3 is the sign and bits 2:0 are the magnitude m. The difference is ((2m+1) × step) >> 3, and it is negated when the sign bit is 1.
- R2: The step comes from a 49-entry table addressed by the current index. The table rises from 16 at index 0 to 1552 at index 48 and holds the fixed values listed in the step ROM.
- R3: The index moves by -1 for m = 0..3, by +2 for m = 4, by +5 for m = 5, by +7 for m = 6 and by +9 for m = 7. This adjustment is applied only when the index is nonzero or m > 3, so an index of 0 stays at 0 for m ≤ 3.
- R4: An index result above 48 is clamped to 48, and a result below 0 is clamped to 0. `step_idx` never exceeds 48.
- R5: The accumulator saturates to the range -2048 to +2047 and never wraps.
- R6: While `rst_n` is low, `sample_out` is 0, `step_idx` is 0 and `out_valid` is 0.
- R7: `clr` high on a clock edge sets `sample_out` and `step_idx` to 0 and makes the next `out_valid` 0, even when `code_valid` is high on the same edge.
- R8: A code sampled on an edge updates `sample_out` and `step_idx` at that edge, and `out_valid` is 1 for the following cycle. On edges without `code_valid`, both values hold and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of accumulator and index |
| code_valid | input | 1 | Strobe: `code` holds a new code this cycle |
| code | input | 4 | Code: bit 3 is the sign, bits 2:0 are the magnitude |
| sample_out | output | ACC_W (12) | Signed decoded sample (the accumulator) |
| step_idx | output | IDX_W (6) | Current step-table index |
| out_valid | output | 1 | High for one cycle after each decoded code |

## Verification
The bench decodes long pseudo-random code streams, with a clear inserted at intervals, and compares the output against an arithmetic model at every step. This drives the index through every table entry in both directions. A wrong table entry, a missing sign or a wrong rounding shift shows up as a sample that drifts from the model.

Directed runs of maximum-magnitude codes push the accumulator into both rails and the index into its ceiling. A design that wraps would jump to the opposite sign. A design that lets the index run past 48 would read an undefined step.

Small codes from a zero index check that the index stays at zero. A design that adapts there unconditionally would leave the index at 0 only by luck of its lower clamp, or would underflow it. Finally, the bench asserts a clear together with a code and checks that the clear wins, and it checks that idle cycles leave the outputs unchanged.

// File: rtl/adpcm_pkg.sv
package adpcm_pkg;

    localparam int STEP_ENTRIES = 49;
    localparam int STEP_MAX_IDX = STEP_ENTRIES - 1;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } dec_state_t;

    // index movement for each code magnitude
    function automatic int idx_move(input logic [2:0] mag);
        int mv;
        case (mag)
            3'd4:    mv = 2;
            3'd5:    mv = 5;
            3'd6:    mv = 7;
            3'd7:    mv = 9;
            default: mv = -1;
        endcase
        return mv;
    endfunction

endpackage

// File: rtl/adpcm_step_rom.sv
module adpcm_step_rom #(
    parameter int IDX_W  = 6,
    parameter int STEP_W = 11
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [STEP_W-1:0] step
);
    int s;

    always_comb begin
        case (idx)
            0: s = 16;    1: s = 17;    2: s = 19;    3: s = 21;
            4: s = 23;    5: s = 25;    6: s = 28;    7: s = 31;
            8: s = 34;    9: s = 37;   10: s = 41;   11: s = 45;
           12: s = 50;   13: s = 55;   14: s = 60;   15: s = 66;
           16: s = 73;   17: s = 80;   18: s = 88;   19: s = 97;
           20: s = 107;  21: s = 118;  22: s = 130;  23: s = 143;
           24: s = 157;  25: s = 173;  26: s = 190;  27: s = 209;
           28: s = 230;  29: s = 253;  30: s = 279;  31: s = 307;
           32: s = 337;  33: s = 371;  34: s = 408;  35: s = 449;
           36: s = 494;  37: s = 544;  38: s = 598;  39: s = 658;
           40: s = 724;  41: s = 796;  42: s = 876;  43: s = 963;
           44: s = 1060; 45: s = 1166; 46: s = 1282; 47: s = 1411;
           default: s = 1552;
        endcase
        step = STEP_W'(s);
    end

endmodule

// File: rtl/adpcm_delta.sv
module adpcm_delta #(
    parameter int STEP_W = 11,
    parameter int OUT_W  = 14
) (
    input  logic [3:0]              code,
    input  logic [STEP_W-1:0]       step,
    output logic signed [OUT_W-1:0] delta
);
    localparam int PROD_W = STEP_W + 4;

    logic [PROD_W-1:0] prod;
    logic [STEP_W:0]   scaled;
    logic [OUT_W-1:0]  ext;

    always_comb begin
        prod   = PROD_W'({code[2:0], 1'b1}) * PROD_W'(step);
        scaled = prod[PROD_W-1:3];
        ext    = OUT_W'(scaled);
        delta  = code[3] ? -$signed(ext) : $signed(ext);
    end

endmodule

// File: rtl/adpcm_index_adapt.sv
module adpcm_index_adapt #(
    parameter int IDX_W   = 6,
    parameter int MAX_IDX = 48
) (
    input  logic [IDX_W-1:0] idx_cur,
    input  logic [2:0]       mag,
    output logic [IDX_W-1:0] idx_nxt
);
    import adpcm_pkg::*;

    localparam int TW = IDX_W + 2;
    localparam logic signed [TW-1:0] MAX_S = TW'(MAX_IDX);

    logic signed [TW-1:0] trial;

    always_comb begin
        trial = $signed(TW'(idx_cur)) + TW'(idx_move(mag));
        if (idx_cur == '0 && !mag[2])
            idx_nxt = idx_cur;
        else if (trial < 0)
            idx_nxt = '0;
        else if (trial > MAX_S)
            idx_nxt = IDX_W'(MAX_IDX);
        else
            idx_nxt = trial[IDX_W-1:0];
    end

endmodule

// File: rtl/adpcm_decoder.sv
module adpcm_decoder #(
    parameter int ACC_W   = 12,
    parameter int STEP_W  = 11,
    parameter int IDX_W   = 6,
    parameter int MAX_IDX = adpcm_pkg::STEP_MAX_IDX
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    code_valid,
    input  logic [3:0]              code,
    output logic signed [ACC_W-1:0] sample_out,
    output logic [IDX_W-1:0]        step_idx,
    output logic                    out_valid
);
    import adpcm_pkg::*;

    localparam int SUM_W = ACC_W + 2;
    localparam logic signed [SUM_W-1:0] POS_LIM = SUM_W'((1 <<< (ACC_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] NEG_LIM = -SUM_W'(1 <<< (ACC_W - 1));

    dec_state_t state_q, state_d;

    logic signed [ACC_W-1:0] acc_q, acc_d;
    logic [IDX_W-1:0]        idx_q, idx_d;
    logic [STEP_W-1:0]       step;
    logic signed [SUM_W-1:0] delta;
    logic signed [SUM_W-1:0] sum;

    adpcm_step_rom #(.IDX_W(IDX_W), .STEP_W(STEP_W)) u_rom (
        .idx  (idx_q),
        .step (step)
    );

    adpcm_delta #(.STEP_W(STEP_W), .OUT_W(SUM_W)) u_delta (
        .code  (code),
        .step  (step),
        .delta (delta)
    );

    adpcm_index_adapt #(.IDX_W(IDX_W), .MAX_IDX(MAX_IDX)) u_adapt (
        .idx_cur (idx_q),
        .mag     (code[2:0]),
        .idx_nxt (idx_d)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (code_valid && !clr) state_d = ST_EMIT;
            ST_EMIT: state_d = (code_valid && !clr) ? ST_EMIT : ST_IDLE;
        endcase
    end

    // saturating sum
    always_comb begin
        sum = SUM_W'(acc_q) + delta;
        if (sum > POS_LIM)      acc_d = POS_LIM[ACC_W-1:0];
        else if (sum < NEG_LIM) acc_d = NEG_LIM[ACC_W-1:0];
        else                    acc_d = sum[ACC_W-1:0];
    end

    // decoding state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            idx_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
            idx_q <= '0;
        end else if (code_valid) begin
            acc_q <= acc_d;
            idx_q <= idx_d;
        end
    end

    // outputs
    always_comb begin
        out_valid  = (state_q == ST_EMIT);
        sample_out = acc_q;
        step_idx   = idx_q;
    end

endmodule

// File: rtl/adpcm_decoder_chk.sv
module adpcm_decoder_chk #(
    parameter int ACC_W   = 12,
    parameter int IDX_W   = 6,
    parameter int MAX_IDX = 48
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    clr,
    input logic                    code_valid,
    input logic [3:0]              code,
    input logic signed [ACC_W-1:0] sample_out,
    input logic [IDX_W-1:0]        step_idx,
    input logic                    out_valid
);
    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_valid && !clr) |=> ($stable(sample_out) && $stable(step_idx)));

    assert_valid_follows_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && !clr) |=> out_valid);

    assert_no_valid_without_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_valid || clr) |=> !out_valid);

    assert_clear_zeroes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sample_out == '0 && step_idx == '0));

    assert_index_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step_idx <= IDX_W'(MAX_IDX));

    assert_zero_index_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && !clr && step_idx == '0 && code[2:0] < 3'd4) |=> step_idx == '0);

    assert_large_code_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && !clr && code[2]) |=>
            (step_idx > $past(step_idx) || $past(step_idx) == IDX_W'(MAX_IDX)));

    always_comb begin
        if (!rst_n) begin
            assert_reset_state_R6: assert (sample_out == '0 && step_idx == '0 && !out_valid);
        end
    end
endmodule

bind adpcm_decoder adpcm_decoder_chk #(
    .ACC_W(ACC_W), .IDX_W(IDX_W), .MAX_IDX(MAX_IDX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .code_valid(code_valid), .code(code),
    .sample_out(sample_out), .step_idx(step_idx), .out_valid(out_valid)
);

// File: tb/tb_adpcm_decoder.sv
`timescale 1ns/1ps
module tb_adpcm_decoder;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr = 1'b0;
    logic              code_valid = 1'b0;
    logic [3:0]        code = 4'd0;
    logic signed [11:0] sample_out;
    logic [5:0]        step_idx;
    logic              out_valid;

    int errors = 0;
    int checks = 0;
    int m_acc = 0;
    int m_idx = 0;
    logic [15:0] lfsr = 16'hACE1;

    int tab[49] = '{16, 17, 19, 21, 23, 25, 28, 31, 34, 37, 41, 45, 50, 55, 60, 66,
                    73, 80, 88, 97, 107, 118, 130, 143, 157, 173, 190, 209, 230, 253,
                    279, 307, 337, 371, 408, 449, 494, 544, 598, 658, 724, 796, 876,
                    963, 1060, 1166, 1282, 1411, 1552};
    int adj[8] = '{-1, -1, -1, -1, 2, 5, 7, 9};

    always #2.5 clk = ~clk;

    adpcm_decoder dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .code_valid(code_valid), .code(code),
        .sample_out(sample_out), .step_idx(step_idx), .out_valid(out_valid)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // decode one code and compare with the arithmetic model
    task automatic apply(input logic [3:0] c);
        int m, d, raw_idx;
        bit sat, iclamp;
        @(negedge clk);
        code_valid = 1'b1;
        code = c;
        @(negedge clk);
        code_valid = 1'b0;
        m = int'(c[2:0]);
        d = ((2 * m + 1) * tab[m_idx]) >>> 3;   // R1 R2
        if (c[3]) d = -d;
        m_acc += d;
        sat = 1'b0;
        if (m_acc > 2047)  begin m_acc = 2047;  sat = 1'b1; end   // R5
        if (m_acc < -2048) begin m_acc = -2048; sat = 1'b1; end
        iclamp = 1'b0;
        if (m_idx != 0 || m > 3) begin   // R3
            raw_idx = m_idx + adj[m];
            if (raw_idx > 48) begin raw_idx = 48; iclamp = 1'b1; end   // R4
            if (raw_idx < 0)  begin raw_idx = 0;  iclamp = 1'b1; end
            m_idx = raw_idx;
        end
        check(sat ? "R5" : "R1 R2", "sample", int'(sample_out), m_acc);
        check(iclamp ? "R4" : "R3", "index", int'(step_idx), m_idx);
        check("R8", "out_valid after code", int'(out_valid), 1);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        m_acc = 0;
        m_idx = 0;
        check("R7", "sample after clear", int'(sample_out), 0);
        check("R7", "index after clear", int'(step_idx), 0);
    endtask

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL R8 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R6", "sample in reset", int'(sample_out), 0);
        check("R6", "index in reset", int'(step_idx), 0);
        check("R6", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // every code from the cleared state (R1, R3 zero-index hold)
        for (int c = 0; c < 16; c++) begin
            do_clear();
            apply(4'(c));
        end

        // idle cycles hold the result and keep out_valid low (R8)
        do_clear();
        apply(4'd5);
        begin
            int s0, i0;
            s0 = int'(sample_out);
            i0 = int'(step_idx);
            repeat (3) @(negedge clk);
            check("R8", "sample held while idle", int'(sample_out), s0);
            check("R8", "index held while idle", int'(step_idx), i0);
            check("R8", "out_valid idle", int'(out_valid), 0);
        end

        // positive rail and index ceiling (R4, R5)
        do_clear();
        for (int k = 0; k < 30; k++) apply(4'd7);
        check("R5", "positive rail", int'(sample_out), 2047);
        check("R4", "index ceiling", int'(step_idx), 48);
        // negative rail
        for (int k = 0; k < 30; k++) apply(4'd15);
        check("R5", "negative rail", int'(sample_out), -2048);

        // walk index down to zero, then small codes must keep it there (R3)
        for (int k = 0; k < 60; k++) apply(4'd1);
        check("R3", "index floor", int'(step_idx), 0);
        apply(4'd3);
        apply(4'd11);

        // clear wins over a simultaneous code (R7)
        apply(4'd6);
        @(negedge clk);
        clr = 1'b1;
        code_valid = 1'b1;
        code = 4'd7;
        @(negedge clk);
        clr = 1'b0;
        code_valid = 1'b0;
        m_acc = 0;
        m_idx = 0;
        check("R7", "sample clear over code", int'(sample_out), 0);
        check("R7", "index clear over code", int'(step_idx), 0);
        check("R7", "no out_valid on clear", int'(out_valid), 0);

        // long pseudo-random streams with periodic clears (R1 R2 R3 R4 R5)
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (n % 97 == 96) do_clear();
            apply(lfsr[3:0] ^ lfsr[11:8]);
        end

        finish_run();
    end
endmodule